// File: doc/BRIEF.md
# Protected Backup-Domain Control Register

This block is one 32-bit control register kept in a battery-backed reset domain. It holds the low-speed crystal oscillator controls, the real-time-clock source and gate, and a software reset for the whole backup domain. A simple single-register bus reaches it with per-byte write enables. Any mix of byte lanes may be written, so word, half-word and byte accesses are all supported. Back-to-back accesses are slowed by a parameterised number of wait states. An access that follows an idle cycle completes at once.

The fields ignore the ordinary system reset. Only the backup-domain reset input, or the software reset bit, clears them. Writes to the oscillator and clock fields take effect only while the external domain-access-enable input is high. A write made while that input is low still finishes normally on the bus. A read-only ready bit reports an oscillator-stable input through a two-flop synchroniser. The ready bit is forced to zero whenever the oscillator enable is off.

Top module: `bkp_ctrl_reg`

## Requirements
- R1: While `bkp_rst_n` is low at a clock edge, every field clears, so after that edge `bus_rdata` reads 0x0000_0000 and `dom_rst_o` is 0.
- R2: Holding `sys_rst_n` low for any number of cycles leaves every field and every field output unchanged.
- R3: While `dom_access_en` is 0, a write does not change bits 0, 2, 9:8 or 15, yet the write still completes with `bus_ready` high.
- R4: The field positions are: bit 0 oscillator enable, bit 1 oscillator ready (read-only), bit 2 oscillator bypass, bits 9:8 RTC source select, bit 15 RTC enable, and bit 16 domain software reset. A write that completes with `bus_ready` high updates these fields at that clock edge, and a read returns them.
- R5: Bits 31:17, 14:10 and 7:3 always read as 0, whatever value is written.
- R6: Byte lane k of `bus_be` gates the update of the fields in bits 8k+7:8k. Lane 0 holds bits 0 and 2, lane 1 holds bits 9:8 and 15, and lane 2 holds bit 16.
- R7: Bit 16 drives `dom_rst_o` from the edge that writes it. While bit 16 is 1, all other fields are cleared and writes to them have no effect. Bit 16 stays set until it is written to 0, and writing it is not gated by `dom_access_en`.
- R8: An access that starts after a cycle with no access sees `bus_ready` high in its first cycle.
- R9: An access that follows a completed access in the very next cycle sees `bus_ready` low for exactly WAIT_STATES cycles (0 to 3) before it completes.
- R10: Bit 1 reads 1 from the second clock edge at which `osc_stable` is sampled high while bit 0 is set. It reads 0 whenever bit 0 is 0.
- R11: `osc_en_o`, `osc_byp_o`, `rtc_sel_o` and `rtc_en_o` always equal bits 0, 2, 9:8 and 15 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| sys_rst_n | input | 1 | System reset, active low, synchronous; resets bus timing only |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, synchronous; clears the fields |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current register value |
| bus_ready | output | 1 | Access completes in this cycle |
| dom_access_en | input | 1 | Unlocks writes to the oscillator and clock fields |
| osc_stable | input | 1 | Asynchronous oscillator-stable indication |
| osc_en_o | output | 1 | Oscillator enable |
| osc_byp_o | output | 1 | Oscillator bypass |
| rtc_sel_o | output | 2 | RTC clock source select |
| rtc_en_o | output | 1 | RTC clock enable |
| dom_rst_o | output | 1 | Backup-domain reset request |

## Verification
`bus_ready` is combinational on the request and the wait state. It is due in the same cycle as the request, or WAIT_STATES cycles later in a back-to-back access. Written fields and their outputs change at the edge that completes the write. The ready bit follows `osc_stable` two edges later, but drops in the same cycle the enable clears. The bench drives inputs 2 ns after a rising edge and advances a behavioural model at each rising edge. It compares every output against that model at the falling edge, so every result is checked in the cycle it is due. Directed checks are made only after the commit edge has passed.

// File: rtl/bkp_pkg.sv
// Package: shared field layout and read-word packing for the backup register.
// Assumes a single 32-bit register; bit positions are fixed by software.
package bkp_pkg;

    localparam int DATA_W      = 32;
    localparam int BE_W        = DATA_W / 8;
    localparam int POS_OSC_EN  = 0;
    localparam int POS_OSC_RDY = 1;
    localparam int POS_OSC_BYP = 2;
    localparam int POS_SEL_LO  = 8;
    localparam int POS_SEL_HI  = 9;
    localparam int POS_RTC_EN  = 15;
    localparam int POS_DRST    = 16;
    localparam int LANE_LO     = 0;
    localparam int LANE_MID    = 1;
    localparam int LANE_HI     = 2;

    typedef struct packed {
        logic       drst;
        logic       rtc_en;
        logic [1:0] rtc_sel;
        logic       osc_byp;
        logic       osc_en;
    } bkp_fields_t;

    // Build the read word; unlisted bits stay zero.
    function automatic logic [DATA_W-1:0] pack_word(bkp_fields_t f, logic rdy);
        logic [DATA_W-1:0] w;
        w                         = '0;
        w[POS_OSC_EN]             = f.osc_en;
        w[POS_OSC_RDY]            = rdy;
        w[POS_OSC_BYP]            = f.osc_byp;
        w[POS_SEL_HI:POS_SEL_LO]  = f.rtc_sel;
        w[POS_RTC_EN]             = f.rtc_en;
        w[POS_DRST]               = f.drst;
        return w;
    endfunction

endpackage

// File: rtl/bkp_wait_gen.sv
// Module: bus timing for the single register.
// An access after an idle cycle completes at once; an access directly after a
// completed one is held for WAIT_STATES cycles. Assumes the requester holds
// bus_req until bus_ready. Reset by the system reset only.
module bkp_wait_gen #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic req,
    output logic ready
);
    localparam int CNT_W = 2;
    localparam logic [CNT_W-1:0] WS_L = CNT_W'(WAIT_STATES);

    logic             last_q;
    logic [CNT_W-1:0] wcnt_q;
    logic             consec;

    // Decide whether this cycle's access completes.
    always_comb begin
        consec = last_q || (wcnt_q != '0);
        ready  = req && (!consec || (wcnt_q == WS_L));
    end

    // Track the previous completion and count elapsed wait cycles.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            last_q <= 1'b0;
            wcnt_q <= '0;
        end else begin
            last_q <= ready;
            if (req && !ready) begin
                wcnt_q <= wcnt_q + 1'b1;
            end else begin
                wcnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/bkp_field_store.sv
// Module: the backup-domain field flops.
// Cleared only by bkp_rst_n or by its own software reset bit. Oscillator and
// RTC fields accept writes only while dom_access_en is high; the reset bit
// is always writable. Each field is updated only when its byte lane is enabled.
module bkp_field_store
    import bkp_pkg::*;
(
    input  logic              clk,
    input  logic              bkp_rst_n,
    input  logic              wr_stb,
    input  logic              dom_access_en,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output bkp_fields_t       fields
);
    bkp_fields_t f_q;
    logic        wr_open;
    wire         unused_wdata = ^{wdata[DATA_W-1:POS_DRST+1], wdata[POS_RTC_EN-1:POS_SEL_HI+1],
                                  wdata[POS_SEL_LO-1:POS_OSC_BYP+1], wdata[POS_OSC_RDY],
                                  be[BE_W-1:LANE_HI+1]};

    // Protected write is open only with access enabled and no domain reset.
    always_comb wr_open = wr_stb && dom_access_en && !f_q.drst;

    // Software domain-reset bit: unprotected, lane 2.
    always_ff @(posedge clk) begin
        if (!bkp_rst_n) begin
            f_q.drst <= 1'b0;
        end else if (wr_stb && be[LANE_HI]) begin
            f_q.drst <= wdata[POS_DRST];
        end
    end

    // Lane 0 fields: oscillator enable and bypass.
    always_ff @(posedge clk) begin
        if (!bkp_rst_n || f_q.drst) begin
            f_q.osc_en  <= 1'b0;
            f_q.osc_byp <= 1'b0;
        end else if (wr_open && be[LANE_LO]) begin
            f_q.osc_en  <= wdata[POS_OSC_EN];
            f_q.osc_byp <= wdata[POS_OSC_BYP];
        end
    end

    // Lane 1 fields: RTC source select and RTC enable.
    always_ff @(posedge clk) begin
        if (!bkp_rst_n || f_q.drst) begin
            f_q.rtc_sel <= 2'b00;
            f_q.rtc_en  <= 1'b0;
        end else if (wr_open && be[LANE_MID]) begin
            f_q.rtc_sel <= wdata[POS_SEL_HI:POS_SEL_LO];
            f_q.rtc_en  <= wdata[POS_RTC_EN];
        end
    end

    assign fields = f_q;
endmodule

// File: rtl/bkp_ready_sync.sv
// Module: multi-flop synchroniser for the oscillator-stable input.
// The chain is held clear while the oscillator is disabled, and the output is
// masked by the enable, so the ready bit drops as soon as the enable clears.
// Assumes STAGES >= 2.
module bkp_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic bkp_rst_n,
    input  logic osc_en,
    input  logic osc_stable,
    output logic rdy
);
    logic [STAGES-1:0] chain_q;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!bkp_rst_n || !osc_en) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= osc_stable;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each later stage re-times the previous one.
        always_ff @(posedge clk) begin
            if (!bkp_rst_n || !osc_en) begin
                chain_q[i] <= 1'b0;
            end else begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign rdy = chain_q[STAGES-1] && osc_en;
endmodule

// File: rtl/bkp_ctrl_reg.sv
// Module: top of the protected backup-domain control register.
// Joins bus timing (system reset domain), the field store and the ready-flag
// synchroniser (backup reset domain). Reads are combinational on the fields.
module bkp_ctrl_reg
    import bkp_pkg::*;
#(
    parameter int WAIT_STATES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              bkp_rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              dom_access_en,
    input  logic              osc_stable,
    output logic              osc_en_o,
    output logic              osc_byp_o,
    output logic [1:0]        rtc_sel_o,
    output logic              rtc_en_o,
    output logic              dom_rst_o
);
    bkp_fields_t fields;
    logic        wr_stb;
    logic        rdy;

    bkp_wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wait (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .req       (bus_req),
        .ready     (bus_ready)
    );

    // A write commits on the edge that ends a completing access.
    always_comb wr_stb = bus_ready && bus_we;

    bkp_field_store u_store (
        .clk           (clk),
        .bkp_rst_n     (bkp_rst_n),
        .wr_stb        (wr_stb),
        .dom_access_en (dom_access_en),
        .be            (bus_be),
        .wdata         (bus_wdata),
        .fields        (fields)
    );

    bkp_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .bkp_rst_n  (bkp_rst_n),
        .osc_en     (fields.osc_en),
        .osc_stable (osc_stable),
        .rdy        (rdy)
    );

    // Drive the read word and the field outputs.
    always_comb begin
        bus_rdata = pack_word(fields, rdy);
        osc_en_o  = fields.osc_en;
        osc_byp_o = fields.osc_byp;
        rtc_sel_o = fields.rtc_sel;
        rtc_en_o  = fields.rtc_en;
        dom_rst_o = fields.drst;
    end
endmodule

// File: rtl/bkp_ctrl_reg_chk.sv
// Module: assertion checker bound to bkp_ctrl_reg. Observes ports only.
module bkp_ctrl_reg_chk #(
    parameter int WAIT_STATES = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic        clk,
    input logic        sys_rst_n,
    input logic        bkp_rst_n,
    input logic        bus_req,
    input logic        bus_ready,
    input logic        dom_access_en,
    input logic        osc_stable,
    input logic [31:0] bus_rdata,
    input logic        osc_en_o,
    input logic        osc_byp_o,
    input logic [1:0]  rtc_sel_o,
    input logic        rtc_en_o,
    input logic        dom_rst_o
);
    logic [2:0] stall_q;

    // Count consecutive stalled cycles of the current access.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            stall_q <= '0;
        end else if (bus_req && !bus_ready) begin
            stall_q <= stall_q + 1'b1;
        end else begin
            stall_q <= '0;
        end
    end

    // R1: a backup reset edge leaves an all-zero register.
    a_r1_bkp_reset_clears: assert property (@(posedge clk)
        !bkp_rst_n |=> (bus_rdata == 32'h0 && !dom_rst_o));

    // R2: system reset alone does not disturb the fields.
    a_r2_sysrst_keeps: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (!sys_rst_n && !bus_req && !dom_rst_o) |=>
        ($stable(osc_en_o) && $stable(rtc_en_o) && $stable(rtc_sel_o) && $stable(osc_byp_o)));

    // R3: with access disabled, protected fields cannot change.
    a_r3_protect_hold: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (!dom_access_en && !dom_rst_o) |=>
        ($stable(osc_en_o) && $stable(osc_byp_o) && $stable(rtc_sel_o) && $stable(rtc_en_o)));

    // R7: a domain reset clears all other fields by the next edge.
    a_r7_domain_clear: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        dom_rst_o |=> (!osc_en_o && !osc_byp_o && rtc_sel_o == 2'b00 && !rtc_en_o));

    // R8: an access after an idle cycle completes at once.
    a_r8_isolated_fast: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_req && !$past(bus_req)) |-> bus_ready);

    // R9: no access stalls for more than WAIT_STATES cycles.
    a_r9_wait_bound: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_req && !bus_ready) |-> (int'(stall_q) < WAIT_STATES));

    // R10: the ready bit rises only after osc_stable was sampled high.
    a_r10_rdy_synced: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        $rose(bus_rdata[1]) |-> $past(osc_stable, SYNC_STAGES));

    // R11: field outputs agree with the read word.
    a_r11_outputs_match: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (bus_rdata[0] == osc_en_o && bus_rdata[15] == rtc_en_o && bus_rdata[16] == dom_rst_o));
endmodule

bind bkp_ctrl_reg bkp_ctrl_reg_chk #(
    .WAIT_STATES (WAIT_STATES),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk           (clk),
    .sys_rst_n     (sys_rst_n),
    .bkp_rst_n     (bkp_rst_n),
    .bus_req       (bus_req),
    .bus_ready     (bus_ready),
    .dom_access_en (dom_access_en),
    .osc_stable    (osc_stable),
    .bus_rdata     (bus_rdata),
    .osc_en_o      (osc_en_o),
    .osc_byp_o     (osc_byp_o),
    .rtc_sel_o     (rtc_sel_o),
    .rtc_en_o      (rtc_en_o),
    .dom_rst_o     (dom_rst_o)
);

// File: tb/bkp_ctrl_reg_bench.sv
// Bench: a behavioural reference model stepped at every rising edge and
// compared at every falling edge, plus directed checks per requirement.
module bkp_ctrl_reg_bench;
    localparam int WS = 2;

    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        bkp_rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        dom_access_en = 1'b0;
    logic        osc_stable = 1'b0;
    logic        osc_en_o, osc_byp_o, rtc_en_o, dom_rst_o;
    logic [1:0]  rtc_sel_o;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    bkp_ctrl_reg #(.WAIT_STATES(WS)) u_bkp_ctrl_reg (
        .clk(clk), .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .dom_access_en(dom_access_en), .osc_stable(osc_stable),
        .osc_en_o(osc_en_o), .osc_byp_o(osc_byp_o), .rtc_sel_o(rtc_sel_o),
        .rtc_en_o(rtc_en_o), .dom_rst_o(dom_rst_o)
    );

    // Reference model state.
    logic [31:0] m_reg = 32'h0;
    bit          m_last = 1'b0;
    int          m_wcnt = 0;
    bit          m_s1 = 1'b0, m_s2 = 1'b0;
    bit          m_rdy;
    logic [31:0] m_nx;

    function automatic bit model_ready();
        return bus_req && (!(m_last || m_wcnt != 0) || m_wcnt == WS);
    endfunction

    function automatic logic [31:0] model_word();
        logic [31:0] w = m_reg;
        w[1] = m_s2 && m_reg[0];
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Step the model at each rising edge.
    always @(posedge clk) begin
        m_rdy = model_ready();
        if (!sys_rst_n) begin
            m_last = 1'b0; m_wcnt = 0;
        end else begin
            m_last = m_rdy;
            m_wcnt = (bus_req && !m_rdy) ? m_wcnt + 1 : 0;
        end
        if (!bkp_rst_n) begin
            m_reg = 32'h0; m_s1 = 1'b0; m_s2 = 1'b0;
        end else begin
            m_nx = m_reg;
            if (m_rdy && bus_we && bus_be[2]) m_nx[16] = bus_wdata[16];
            if (m_reg[16]) begin
                m_nx[15:0] = 16'h0;
            end else if (m_rdy && bus_we && dom_access_en) begin
                if (bus_be[0]) begin m_nx[0] = bus_wdata[0]; m_nx[2] = bus_wdata[2]; end
                if (bus_be[1]) begin m_nx[9:8] = bus_wdata[9:8]; m_nx[15] = bus_wdata[15]; end
            end
            if (!m_reg[0]) begin m_s1 = 1'b0; m_s2 = 1'b0; end
            else begin m_s2 = m_s1; m_s1 = osc_stable; end
            m_reg = m_nx;
        end
    end

    // Compare every output against the model at each falling edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check({cur_tag, " rdata"}, bus_rdata, model_word());
            check({cur_tag, " ready"}, {31'h0, bus_ready}, {31'h0, model_ready()});
            check({cur_tag, " outs R11"}, {27'h0, dom_rst_o, rtc_en_o, rtc_sel_o, osc_byp_o},
                  {27'h0, m_reg[16], m_reg[15], m_reg[9:8], m_reg[2]});
            check({cur_tag, " osc_en R11"}, {31'h0, osc_en_o}, {31'h0, m_reg[0]});
        end
    end

    task automatic idle(int n);
        bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    // One access; returns with req still high, 2 ns after the commit edge.
    task automatic access(bit we, logic [31:0] d, logic [3:0] be, output int waits);
        bit r;
        bus_req = 1'b1; bus_we = we; bus_wdata = d; bus_be = be;
        waits = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); r = bus_ready;
            @(posedge clk); #2;
            if (r) break;
            waits++;
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(posedge clk);
        #2; cmp_on = 1'b1;
        @(posedge clk); #2;
        sys_rst_n = 1'b1; bkp_rst_n = 1'b1;
        idle(2);
        check("R1 reset value", bus_rdata, 32'h0);

        cur_tag = "R4";
        dom_access_en = 1'b1; osc_stable = 1'b1;
        access(1'b1, 32'h0000_8305, 4'hF, w);
        check("R8 isolated waits", w, 0);
        idle(1);
        check("R10 rdy not yet", {31'h0, bus_rdata[1]}, 32'h0);
        idle(1);
        check("R10 rdy after two edges", {31'h0, bus_rdata[1]}, 32'h1);
        check("R4 readback", bus_rdata, 32'h0000_8307);
        check("R11 rtc_sel_o", {30'h0, rtc_sel_o}, 32'h3);

        cur_tag = "R5";
        access(1'b1, 32'hFFFE_FFFF, 4'hF, w);
        idle(1);
        check("R5 reserved zero", bus_rdata & 32'hFFFE_7CF8, 32'h0);

        cur_tag = "R6";
        access(1'b1, 32'h0, 4'b0010, w);
        idle(1);
        check("R6 lane1 only", bus_rdata, 32'h0000_0007);
        access(1'b1, 32'h0000_8300, 4'b0001, w);
        idle(1);
        check("R6 lane0 only", bus_rdata, 32'h0);
        check("R10 rdy off with enable", {31'h0, bus_rdata[1]}, 32'h0);

        cur_tag = "R9";
        access(1'b0, 32'h0, 4'h0, w);
        check("R8 first read", w, 0);
        access(1'b0, 32'h0, 4'h0, w);
        check("R9 back-to-back waits", w, WS);
        access(1'b1, 32'h0000_0100, 4'h3, w);
        check("R9 third waits", w, WS);
        idle(1);
        check("R9 write after waits", bus_rdata, 32'h0000_0100);

        cur_tag = "R3";
        dom_access_en = 1'b0;
        access(1'b1, 32'h0000_8305, 4'hF, w);
        check("R3 write completes", w, 0);
        idle(1);
        check("R3 protected unchanged", bus_rdata, 32'h0000_0100);
        dom_access_en = 1'b1;
        access(1'b1, 32'h0000_8105, 4'hF, w);
        dom_access_en = 1'b0;
        idle(1);
        access(1'b1, 32'h0, 4'hF, w);
        idle(3);
        check("R3 locked again", bus_rdata, 32'h0000_8107);

        cur_tag = "R2";
        sys_rst_n = 1'b0;
        idle(3);
        sys_rst_n = 1'b1;
        idle(1);
        check("R2 fields survive", bus_rdata, 32'h0000_8107);

        cur_tag = "R7";
        access(1'b1, 32'h0001_0000, 4'b0100, w);
        idle(1);
        check("R7 dom_rst_o", {31'h0, dom_rst_o}, 32'h1);
        check("R7 others cleared", bus_rdata, 32'h0001_0000);
        dom_access_en = 1'b1;
        access(1'b1, 32'h0000_8305, 4'b0011, w);
        idle(2);
        check("R7 writes blocked", bus_rdata, 32'h0001_0000);
        access(1'b1, 32'h0, 4'b0100, w);
        idle(1);
        check("R7 cleared by write", bus_rdata, 32'h0);
        access(1'b1, 32'h0000_8204, 4'hF, w);
        idle(1);
        check("R7 writable after", bus_rdata, 32'h0000_8204);

        cur_tag = "R1";
        bkp_rst_n = 1'b0;
        idle(2);
        bkp_rst_n = 1'b1;
        idle(1);
        check("R1 backup reset", bus_rdata, 32'h0);
        check("R1 dom_rst_o", {31'h0, dom_rst_o}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule